// File: doc/BRIEF.md
# E3 Frame Alignment Serial Framer

This block finds and holds frame alignment in a serial E3 bit stream. Bits arrive one per accepted clock, qualified by a bit-enable strobe. The block slides a ten-bit window over the stream and tests every bit position in turn for the alignment word `1111010000`. When the word appears, the block treats that spot as a candidate frame start. It then checks the same spot one frame length later until the candidate has proved itself. After that it holds lock, and it tolerates isolated errors until a run of misses forces a new search.

The outputs are an in-frame flag, a bit counter giving the position of the most recently accepted bit within the frame, and a one-cycle pulse each time a locked frame begins. Downstream logic uses the counter and the pulse to find the overhead and payload bits. The frame length, the word, the number of good words needed for lock and the number of misses that end it are all parameters.

Top module: `e3fas_framer`

## Requirements
- R1: After reset, `in_frame` is 0, `frame_pulse` is 0 and `bit_pos` is 0.
- R2: The alignment word is `1111010000` (parameter `SYNC_WORD`). The first of its bits to arrive is the leftmost one. The word is matched against the last `SYNC_BITS` accepted bits.
- R3: While searching, every accepted bit ends a candidate window. On a match, `bit_pos` becomes `SYNC_BITS-1` (9), so the word occupies positions 0..9, and confirmation begins with one good word counted.
- R4: `in_frame` rises in the cycle after the bit that completes the `LOCK_HITS`-th (3) consecutive good word at `FRAME_BITS` spacing. It stays low after only two good words.
- R5: During confirmation, a mismatch at the expected position returns the block to search. The search resumes with the next accepted bit, one bit after the rejected candidate, so a word shifted by one bit is found at once.
- R6: While locked, `in_frame` falls in the cycle after the bit that completes the `DROP_MISSES`-th (4) consecutive bad word. Three consecutive bad words keep lock.
- R7: While locked, one good word clears the miss count, so misses must be consecutive to end lock.
- R8: `bit_pos` advances by one for each accepted bit and wraps from `FRAME_BITS-1` to 0. A search match reloads it to 9 instead.
- R9: `frame_pulse` is high for exactly one cycle, in the cycle after the block accepts a bit at position 0 while locked. It is never high while `in_frame` is low.
- R10: While `bit_en` is low, `bit_in` is ignored and `in_frame`, `bit_pos` and the internal counters keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High when `bit_in` carries a valid stream bit this cycle |
| bit_in | input | 1 | Serial E3 data bit |
| in_frame | output | 1 | High while frame alignment is held |
| frame_pulse | output | 1 | One-cycle pulse at the start of each locked frame |
| bit_pos | output | $clog2(FRAME_BITS) | Position of the most recently accepted bit within the frame |

## Verification
The bench builds the framer with `FRAME_BITS` set to 48, a short frame, and keeps the ten-bit word and the default lock and drop counts. The short frame lets a single run cover many lock, loss and relock cycles. It also puts a shifted-candidate recovery and a long stretch of random bits with random strobe gaps within a few thousand clocks. In that random stretch, false matches in the payload exercise the search and confirmation paths against the reference model.

// File: rtl/e3fas_pkg.sv
package e3fas_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_VERIFY  = 2'd1,
        ST_HOLD    = 2'd2
    } align_state_e;

endpackage

// File: rtl/e3fas_window.sv
module e3fas_window #(
    parameter int unsigned               SYNC_BITS = 10,
    parameter logic [SYNC_BITS-1:0]      SYNC_WORD = 10'b1111010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic word_hit
);

    typedef struct packed {
        logic [SYNC_BITS-1:0] shreg;
    } win_t;

    win_t win_d, win_q;

    // The oldest bit sits at the MSB, so the first bit received lines up
    // with the leftmost bit of the word.
    always_comb begin
        win_d = win_q;
        if (bit_en) begin
            win_d.shreg = {win_q.shreg[SYNC_BITS-2:0], bit_in};
        end
        word_hit = bit_en && (win_d.shreg == SYNC_WORD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (win_q.shreg[0] == $past(bit_in)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(win_q.shreg));

endmodule

// File: rtl/e3fas_position.sv
module e3fas_position #(
    parameter int unsigned FRAME_BITS = 1536,
    parameter int unsigned SYNC_BITS  = 10,
    localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             reload,
    output logic [POS_W-1:0] pos,
    output logic             next_at_check,
    output logic             next_at_start
);

    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_CHECK = POS_W'(SYNC_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [POS_W-1:0] pos_inc;

    always_comb begin
        pos_inc       = (cnt_q.pos == POS_LAST) ? '0 : cnt_q.pos + POS_W'(1);
        next_at_check = (pos_inc == POS_CHECK);
        next_at_start = (pos_inc == '0);
        cnt_d         = cnt_q;
        if (reload) begin
            cnt_d.pos = POS_CHECK;
        end else if (bit_en) begin
            cnt_d.pos = pos_inc;
        end
        pos = cnt_q.pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.pos <= POS_LAST);

    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q.pos == POS_CHECK));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !reload && cnt_q.pos == POS_LAST) |=> (cnt_q.pos == '0));

    assert_pos_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt_q.pos));

endmodule

// File: rtl/e3fas_lock_fsm.sv
module e3fas_lock_fsm
    import e3fas_pkg::*;
#(
    parameter int unsigned LOCK_HITS   = 3,
    parameter int unsigned DROP_MISSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic word_hit,
    input  logic at_check,
    input  logic at_start,
    output logic reload,
    output logic in_frame,
    output logic frame_pulse
);

    localparam int unsigned CNT_MAX = (LOCK_HITS > DROP_MISSES) ? LOCK_HITS : DROP_MISSES;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HITS_NEED  = CNT_W'(LOCK_HITS);
    localparam logic [CNT_W-1:0] MISS_LIMIT = CNT_W'(DROP_MISSES);

    typedef struct packed {
        align_state_e     state;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] miss;
        logic             pulse;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.pulse = 1'b0;
        reload      = 1'b0;
        if (bit_en) begin
            unique case (fsm_q.state)
                ST_HUNT: begin
                    if (word_hit) begin
                        reload = 1'b1;
                        if (LOCK_HITS <= 1) begin
                            fsm_d.state = ST_HOLD;
                            fsm_d.miss  = '0;
                        end else begin
                            fsm_d.state = ST_VERIFY;
                            fsm_d.hits  = CNT_W'(1);
                        end
                    end
                end
                ST_VERIFY: begin
                    if (at_check) begin
                        if (word_hit) begin
                            if (fsm_q.hits + CNT_W'(1) >= HITS_NEED) begin
                                fsm_d.state = ST_HOLD;
                                fsm_d.hits  = '0;
                                fsm_d.miss  = '0;
                            end else begin
                                fsm_d.hits = fsm_q.hits + CNT_W'(1);
                            end
                        end else begin
                            fsm_d.state = ST_HUNT;
                            fsm_d.hits  = '0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (at_check) begin
                        if (word_hit) begin
                            fsm_d.miss = '0;
                        end else if (fsm_q.miss + CNT_W'(1) >= MISS_LIMIT) begin
                            fsm_d.state = ST_HUNT;
                            fsm_d.miss  = '0;
                        end else begin
                            fsm_d.miss = fsm_q.miss + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    fsm_d.state = ST_HUNT;
                end
            endcase
            fsm_d.pulse = (fsm_d.state == ST_HOLD) && at_start && !reload;
        end
        in_frame    = (fsm_q.state == ST_HOLD);
        frame_pulse = fsm_q.pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_HUNT, hits: '0, miss: '0, pulse: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assert_lock_via_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCK_HITS > 1 && $rose(in_frame)) |-> ($past(fsm_q.state) == ST_VERIFY));

    assert_drop_after_misses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> ($past(fsm_q.miss) == MISS_LIMIT - CNT_W'(1)));

    assert_good_clears_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsm_q.state == ST_HOLD && at_check && word_hit) |=> (fsm_q.miss == '0));

    assert_verify_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsm_q.state == ST_VERIFY && at_check && !word_hit) |=> (fsm_q.state == ST_HUNT));

    assert_pulse_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> in_frame);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse);

endmodule

// File: rtl/e3fas_framer.sv
module e3fas_framer #(
    parameter int unsigned               FRAME_BITS  = 1536,
    parameter int unsigned               SYNC_BITS   = 10,
    parameter logic [SYNC_BITS-1:0]      SYNC_WORD   = 10'b1111010000,
    parameter int unsigned               LOCK_HITS   = 3,
    parameter int unsigned               DROP_MISSES = 4,
    localparam int unsigned              POS_W       = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             in_frame,
    output logic             frame_pulse,
    output logic [POS_W-1:0] bit_pos
);

    logic word_hit;
    logic reload;
    logic at_check;
    logic at_start;

    e3fas_window #(
        .SYNC_BITS (SYNC_BITS),
        .SYNC_WORD (SYNC_WORD)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .word_hit (word_hit)
    );

    e3fas_position #(
        .FRAME_BITS (FRAME_BITS),
        .SYNC_BITS  (SYNC_BITS)
    ) u_position (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en        (bit_en),
        .reload        (reload),
        .pos           (bit_pos),
        .next_at_check (at_check),
        .next_at_start (at_start)
    );

    e3fas_lock_fsm #(
        .LOCK_HITS   (LOCK_HITS),
        .DROP_MISSES (DROP_MISSES)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .word_hit    (word_hit),
        .at_check    (at_check),
        .at_start    (at_start),
        .reload      (reload),
        .in_frame    (in_frame),
        .frame_pulse (frame_pulse)
    );

    assert_pulse_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (bit_pos == '0 && in_frame));

    assert_pulse_needs_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> $past(bit_en));

endmodule

// File: tb/test_e3fas_framer.sv
module test_e3fas_framer;

    localparam int unsigned F     = 48;
    localparam int unsigned PW    = 10;
    localparam logic [PW-1:0] SW  = 10'b1111010000;
    localparam int unsigned POS_W = $clog2(F);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic in_frame;
    logic frame_pulse;
    logic [POS_W-1:0] bit_pos;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    bit finished = 1'b0;
    int pulses_seen = 0;

    // Reference model state
    int m_state = 0;   // 0 hunting, 1 verifying, 2 locked
    int m_pos = 0;
    int m_hits = 0;
    int m_miss = 0;
    bit m_pulse = 1'b0;
    bit m_hist[$];

    always #10 clk = ~clk;

    e3fas_framer #(
        .FRAME_BITS (F)
    ) i_e3fas_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .bit_in      (bit_in),
        .in_frame    (in_frame),
        .frame_pulse (frame_pulse),
        .bit_pos     (bit_pos)
    );

    task automatic check(input int actual, input int expected, input string tag);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
        end
    endtask

    // Behavioural model, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_pulse = 1'b0;
            m_hist.delete();
        end else if (bit_en) begin
            bit hit;
            int npos;
            m_hist.push_back(bit_in);
            if (m_hist.size() > PW) void'(m_hist.pop_front());
            hit = (m_hist.size() == PW);
            for (int k = 0; k < PW; k++) begin
                if (hit && m_hist[k] != SW[PW-1-k]) hit = 1'b0;
            end
            npos = (m_pos == F - 1) ? 0 : m_pos + 1;
            if (m_state == 0) begin
                if (hit) begin npos = PW - 1; m_state = 1; m_hits = 1; end
            end else if (m_state == 1) begin
                if (npos == PW - 1) begin
                    if (hit) begin
                        m_hits++;
                        if (m_hits == 3) begin m_state = 2; m_miss = 0; end
                    end else begin
                        m_state = 0;
                    end
                end
            end else begin
                if (npos == PW - 1) begin
                    if (hit) m_miss = 0;
                    else begin
                        m_miss++;
                        if (m_miss == 4) begin m_state = 0; m_miss = 0; end
                    end
                end
            end
            m_pos = npos;
            m_pulse = (m_state == 2) && (npos == 0);
        end else begin
            m_pulse = 1'b0;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(int'(in_frame), int'(m_state == 2), "R4/R6 in_frame vs model");
            check(int'(bit_pos), m_pos, "R8 bit_pos vs model");
            check(int'(frame_pulse), int'(m_pulse), "R9 frame_pulse vs model");
            if (frame_pulse) pulses_seen++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    bit gaps_on = 1'b0;

    task automatic send_bit(input bit b);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        if (gaps_on && ($urandom % 4 == 0)) begin
            repeat (1 + $urandom % 3) begin
                bit_in = 1'($urandom);
                @(negedge clk);
            end
        end
    endtask

    task automatic send_word(input bit good);
        for (int i = PW - 1; i >= 0; i--) begin
            bit b;
            b = SW[i];
            if (!good && i == PW - 1) b = 1'b0;
            send_bit(b);
        end
    endtask

    task automatic send_payload(input int n, input bit rnd);
        for (int i = 0; i < n; i++) send_bit(rnd ? 1'($urandom) : 1'b0);
    endtask

    task automatic send_frame(input bit good, input bit rnd);
        send_word(good);
        send_payload(F - PW, rnd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(int'(in_frame), 0, "R1 in_frame at reset");
        check(int'(frame_pulse), 0, "R1 frame_pulse at reset");
        check(int'(bit_pos), 0, "R1 bit_pos at reset");
        rst_n = 1'b1;
        compare_on = 1'b1;

        // R2/R3: unaligned start, first word found by serial search
        send_payload(7, 1'b0);
        send_word(1'b1);
        check(int'(bit_pos), PW - 1, "R3 bit_pos reloaded on match");
        check(int'(in_frame), 0, "R3 no lock on first word");
        send_payload(F - PW, 1'b0);
        check(int'(bit_pos), F - 1, "R8 bit_pos at frame end");
        send_frame(1'b1, 1'b0);
        check(int'(in_frame), 0, "R4 two words not enough");
        send_word(1'b1);
        check(int'(in_frame), 1, "R4 lock on third word");
        send_payload(F - PW, 1'b0);

        // R9: one pulse per locked frame
        pulses_seen = 0;
        send_frame(1'b1, 1'b0);
        send_frame(1'b1, 1'b0);
        check(pulses_seen, 2, "R9 pulses over two locked frames");

        // R10: idle strobe, data toggling
        begin
            int held_pos;
            held_pos = int'(bit_pos);
            for (int i = 0; i < 6; i++) begin
                bit_in = ~bit_in;
                @(negedge clk);
            end
            check(int'(bit_pos), held_pos, "R10 bit_pos held while idle");
            check(int'(in_frame), 1, "R10 in_frame held while idle");
        end

        // R6/R7: miss counting while locked
        repeat (3) send_frame(1'b0, 1'b0);
        check(int'(in_frame), 1, "R6 three misses keep lock");
        send_frame(1'b1, 1'b0);
        repeat (3) send_frame(1'b0, 1'b0);
        check(int'(in_frame), 1, "R7 good word cleared misses");
        send_word(1'b0);
        check(int'(in_frame), 0, "R6 fourth miss drops lock");
        pulses_seen = 0;
        send_payload(F - PW, 1'b0);
        check(pulses_seen, 0, "R9 no pulse after loss");

        // R5: confirmation failure resets the count
        send_frame(1'b1, 1'b0);
        send_frame(1'b0, 1'b0);
        send_frame(1'b1, 1'b0);
        send_frame(1'b1, 1'b0);
        check(int'(in_frame), 0, "R5 count restarted after verify miss");
        send_word(1'b1);
        check(int'(in_frame), 1, "R5 lock after fresh three words");
        send_payload(F - PW, 1'b0);

        // R5: shifted candidate found one bit later; lose lock first
        repeat (4) send_frame(1'b0, 1'b0);
        check(int'(in_frame), 0, "R6 lost before shift test");
        send_frame(1'b1, 1'b0);
        send_bit(1'b0);
        send_word(1'b1);
        check(int'(bit_pos), PW - 1, "R5 shifted word realigns counter");
        send_payload(F - PW, 1'b0);
        send_frame(1'b1, 1'b0);
        send_word(1'b1);
        check(int'(in_frame), 1, "R5 lock on shifted alignment");
        send_payload(F - PW, 1'b0);

        // Random payload and strobe gaps, model compare every cycle
        gaps_on = 1'b1;
        repeat (10) send_frame(1'b1, 1'b1);
        check(int'(in_frame), int'(m_state == 2), "R4 in_frame after random frames");
        send_payload(1500, 1'b1);
        repeat (6) send_frame(($urandom % 3) != 0, 1'b1);
        gaps_on = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule